// File: doc/BRIEF.md
# SPI Word Packer and Unpacker

This block converts between a byte stream and the 32-bit words that move through the transmit and receive FIFOs of an SPI engine. The SPI word size is 1, 2 or 4 bytes, and it is chosen from the programmed bits-per-word value. On the transmit side, the block collects the bytes of one SPI word and writes them as a single FIFO word, with the first byte in the top byte lane. On the receive side, it reads right-justified FIFO words and emits their used bytes, most significant first.

A transfer begins with a one-cycle `start` pulse that latches the bit width, the byte length and two mode bits. One mode bit replaces transmit data with all-zero dummy words. The other consumes received words without emitting bytes. Both sides stop at the byte length. Either side may be held off by a full transmit FIFO or an empty receive FIFO, and it then resumes at the same position. The word count of the transfer is reported. A length that is not a whole number of words raises an error and nothing moves.

Top module: `spi_word_pack`

## Requirements
- R1: The word size in bytes is 1 when `cfg_bits` is 8 or less (0 included), 2 when it is 9 to 16, and 4 when it is 17 to 32.
- R2: One cycle after an accepted `start`, `word_cnt` equals the byte length divided by the word size. After a rejected start it is 0.
- R3: A transmit word carries its byte k (k = 0 is the first accepted) in bits [31-8k:24-8k]. Bits below the used bytes are zero.
- R4: A received word is right-justified. Its used bytes are emitted on `rx_byte` from the most significant used byte down to bit 0. Bits above the used bytes are ignored.
- R5: With `cfg_no_tx` set, `tx_byte_ready` stays low and one all-zero word is written for each SPI word.
- R6: With `cfg_no_rx` set, one FIFO word is popped for each SPI word and `rx_byte_valid` stays low.
- R7: `txf_wr` is high only in a cycle whose preceding cycle had `txf_full` low. After a stall, the words continue in order with none lost.
- R8: `rxf_rd` is never high while `rxf_empty` is high. After a gap, the bytes continue in order.
- R9: Exactly the byte length is accepted on transmit and emitted or discarded on receive. Data offered beyond it is left untouched.
- R10: `done` rises one cycle after the last received byte is counted, `busy` falls at the same time, and `done` holds until the next `start`.
- R11: A length that is not a multiple of the word size sets `len_err` and leaves `busy` low. No byte is accepted and no FIFO access is made.
- R12: After reset, `busy`, `done`, `len_err`, `txf_wr`, `rx_byte_valid` and `word_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that latches the configuration and begins a transfer |
| cfg_bits | input | 6 | Bits per SPI word, 1 to 32 |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_no_tx | input | 1 | Send zero dummy words instead of byte data |
| cfg_no_rx | input | 1 | Discard received words |
| tx_byte_valid | input | 1 | A transmit byte is offered |
| tx_byte | input | 8 | Transmit byte |
| tx_byte_ready | output | 1 | The offered byte is taken at this edge |
| txf_full | input | 1 | Transmit FIFO is full |
| txf_wr | output | 1 | Registered write strobe to the transmit FIFO |
| txf_data | output | WORD_W | Packed transmit word |
| rxf_empty | input | 1 | Receive FIFO is empty |
| rxf_data | input | WORD_W | Head word of the receive FIFO (show-ahead) |
| rxf_rd | output | 1 | Pop of the receive FIFO head at this edge |
| rx_byte_valid | output | 1 | A received byte is on `rx_byte` |
| rx_byte | output | 8 | Received byte |
| word_cnt | output | LEN_W | SPI words in the current transfer |
| busy | output | 1 | Receive side is still counting |
| done | output | 1 | All received bytes counted |
| len_err | output | 1 | The last start was rejected for length |

## Verification
The packer and unpacker are driven with 1-, 2- and 4-byte words, using distinct byte values. This separates a byte-lane mix-up from a correct placement. Received 2-byte words carry nonzero bits above their used bytes, which exposes any failure to ignore them. Bit widths on both sides of each decode boundary (8/9, 16/17) separate the three word sizes through the word count and the read count. Stall patterns on both FIFOs, surplus source data beyond the length, the two dummy modes and a misaligned length cover the flow-control, stop and reject paths.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;

  localparam int BPW_W = 6;

  typedef enum logic [1:0] {
    WS_1 = 2'd0,
    WS_2 = 2'd1,
    WS_4 = 2'd2
  } wsize_e;

  function automatic wsize_e ws_from_bits(input logic [BPW_W-1:0] bits);
    if (bits <= 6'd8)       return WS_1;
    else if (bits <= 6'd16) return WS_2;
    else                    return WS_4;
  endfunction

  function automatic logic [2:0] ws_bytes(input wsize_e ws);
    case (ws)
      WS_1:    return 3'd1;
      WS_2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] ws_shift(input wsize_e ws);
    case (ws)
      WS_1:    return 2'd0;
      WS_2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/spi_pack_cfg.sv
module spi_pack_cfg
  import spi_pack_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic [BPW_W-1:0] bits,
  input  logic [LEN_W-1:0] len,
  output wsize_e           ws,
  output logic [LEN_W-1:0] nwords,
  output logic             bad
);
  logic [LEN_W-1:0] lane_mask;

  always_comb begin
    ws        = ws_from_bits(bits);
    nwords    = len >> ws_shift(ws);
    lane_mask = {{(LEN_W-3){1'b0}}, ws_bytes(ws) - 3'd1};
    bad       = (len & lane_mask) != '0;
  end
endmodule

// File: rtl/spi_pack_tx.sv
module spi_pack_tx
  import spi_pack_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              no_tx,
  input  wsize_e            ws,
  input  logic [LEN_W-1:0]  len,
  input  logic              byte_valid,
  input  logic [7:0]        byte_in,
  output logic              byte_ready,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [WORD_W-1:0] fifo_data
);
  localparam int SH_W = $clog2(WORD_W);

  logic              run;
  logic              pend;
  logic [WORD_W-1:0] pend_data;
  logic [WORD_W-1:0] acc;
  logic [1:0]        idx;
  logic [LEN_W-1:0]  cnt;
  logic [2:0]        wsb;
  logic [WORD_W-1:0] merged;
  logic [SH_W-1:0]   lane_sh;
  logic              last_lane;

  always_comb begin
    wsb        = ws_bytes(ws);
    lane_sh    = SH_W'({idx, 3'b000});
    merged     = acc | ({byte_in, {(WORD_W-8){1'b0}}} >> lane_sh);
    last_lane  = {1'b0, idx} == (wsb - 3'd1);
    byte_ready = run && !pend && !no_tx && (cnt != len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      pend      <= 1'b0;
      pend_data <= '0;
      acc       <= '0;
      idx       <= '0;
      cnt       <= '0;
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
    end else begin
      fifo_wr <= 1'b0;
      if (go) begin
        run  <= 1'b1;
        pend <= 1'b0;
        acc  <= '0;
        idx  <= '0;
        cnt  <= '0;
      end else if (run) begin
        if (pend) begin
          if (!fifo_full) begin
            fifo_wr   <= 1'b1;
            fifo_data <= pend_data;
            pend      <= 1'b0;
          end
        end else if (cnt == len) begin
          run <= 1'b0;
        end else if (no_tx) begin
          pend      <= 1'b1;
          pend_data <= '0;
          cnt       <= cnt + LEN_W'(wsb);
        end else if (byte_valid) begin
          cnt <= cnt + 1'b1;
          if (last_lane) begin
            pend      <= 1'b1;
            pend_data <= merged;
            acc       <= '0;
            idx       <= '0;
          end else begin
            acc <= merged;
            idx <= idx + 2'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_pack_rx.sv
module spi_pack_rx
  import spi_pack_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              active,
  input  logic              no_rx,
  input  wsize_e            ws,
  input  logic [LEN_W-1:0]  len,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_rd,
  output logic              byte_valid,
  output logic [7:0]        byte_out,
  output logic [LEN_W-1:0]  cnt
);
  localparam int SH_W = $clog2(WORD_W);

  logic [WORD_W-1:0] hold;
  logic              holding;
  logic [1:0]        idx;
  logic [2:0]        wsb;
  logic [SH_W-1:0]   lane_sh;
  logic [WORD_W-1:0] shifted;
  logic              last_lane;

  always_comb begin
    wsb       = ws_bytes(ws);
    lane_sh   = SH_W'({(wsb - 3'd1 - {1'b0, idx}), 3'b000});
    shifted   = hold >> lane_sh;
    last_lane = {1'b0, idx} == (wsb - 3'd1);
    fifo_rd   = active && !clr && !holding && (cnt != len) && !fifo_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold       <= '0;
      holding    <= 1'b0;
      idx        <= '0;
      cnt        <= '0;
      byte_valid <= 1'b0;
      byte_out   <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (clr) begin
        holding <= 1'b0;
        idx     <= '0;
        cnt     <= '0;
      end else begin
        if (fifo_rd) begin
          if (no_rx) begin
            cnt <= cnt + LEN_W'(wsb);
          end else begin
            hold    <= fifo_data;
            holding <= 1'b1;
            idx     <= '0;
          end
        end
        if (holding) begin
          byte_out   <= shifted[7:0];
          byte_valid <= 1'b1;
          cnt        <= cnt + 1'b1;
          if (last_lane) holding <= 1'b0;
          else           idx     <= idx + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_word_pack.sv
module spi_word_pack
  import spi_pack_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [5:0]        cfg_bits,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_no_tx,
  input  logic              cfg_no_rx,
  input  logic              tx_byte_valid,
  input  logic [7:0]        tx_byte,
  output logic              tx_byte_ready,
  input  logic              txf_full,
  output logic              txf_wr,
  output logic [WORD_W-1:0] txf_data,
  input  logic              rxf_empty,
  input  logic [WORD_W-1:0] rxf_data,
  output logic              rxf_rd,
  output logic              rx_byte_valid,
  output logic [7:0]        rx_byte,
  output logic [LEN_W-1:0]  word_cnt,
  output logic              busy,
  output logic              done,
  output logic              len_err
);
  wsize_e           ws_new;
  logic [LEN_W-1:0] nwords_new;
  logic             bad_new;

  wsize_e           ws_q;
  logic [LEN_W-1:0] len_q;
  logic             no_tx_q;
  logic             no_rx_q;
  logic [LEN_W-1:0] rx_cnt;
  logic             go;

  spi_pack_cfg #(.LEN_W(LEN_W)) u_cfg (
    .bits   (cfg_bits),
    .len    (cfg_len),
    .ws     (ws_new),
    .nwords (nwords_new),
    .bad    (bad_new)
  );

  assign go = start && !bad_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q     <= WS_1;
      len_q    <= '0;
      no_tx_q  <= 1'b0;
      no_rx_q  <= 1'b0;
      word_cnt <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      len_err  <= 1'b0;
    end else if (start) begin
      ws_q    <= ws_new;
      len_q   <= cfg_len;
      no_tx_q <= cfg_no_tx;
      no_rx_q <= cfg_no_rx;
      done    <= 1'b0;
      if (bad_new) begin
        len_err  <= 1'b1;
        busy     <= 1'b0;
        word_cnt <= '0;
      end else begin
        len_err  <= 1'b0;
        busy     <= 1'b1;
        word_cnt <= nwords_new;
      end
    end else if (busy && rx_cnt == len_q) begin
      busy <= 1'b0;
      done <= 1'b1;
    end
  end

  spi_pack_tx #(.LEN_W(LEN_W), .WORD_W(WORD_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .no_tx      (no_tx_q),
    .ws         (ws_q),
    .len        (len_q),
    .byte_valid (tx_byte_valid),
    .byte_in    (tx_byte),
    .byte_ready (tx_byte_ready),
    .fifo_full  (txf_full),
    .fifo_wr    (txf_wr),
    .fifo_data  (txf_data)
  );

  spi_pack_rx #(.LEN_W(LEN_W), .WORD_W(WORD_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .clr        (start),
    .active     (busy),
    .no_rx      (no_rx_q),
    .ws         (ws_q),
    .len        (len_q),
    .fifo_empty (rxf_empty),
    .fifo_data  (rxf_data),
    .fifo_rd    (rxf_rd),
    .byte_valid (rx_byte_valid),
    .byte_out   (rx_byte),
    .cnt        (rx_cnt)
  );
endmodule

// File: rtl/spi_pack_chk.sv
module spi_pack_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              txf_wr,
  input logic              txf_full,
  input logic [WORD_W-1:0] txf_data,
  input logic              rxf_rd,
  input logic              rxf_empty,
  input logic              rx_byte_valid,
  input logic              busy,
  input logic              done,
  input logic              len_err,
  input logic              no_tx_q,
  input logic              no_rx_q
);
  assert_wr_after_room_R7: assert property (@(posedge clk) disable iff (rst)
    txf_wr |-> $past(!txf_full));

  assert_rd_not_empty_R8: assert property (@(posedge clk) disable iff (rst)
    rxf_rd |-> !rxf_empty);

  assert_dummy_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (txf_wr && no_tx_q) |-> (txf_data == '0));

  assert_discard_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    no_rx_q |-> !rx_byte_valid);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_err_idle_R11: assert property (@(posedge clk) disable iff (rst)
    len_err |-> (!busy && !done));
endmodule

bind spi_word_pack spi_pack_chk #(.WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .txf_wr        (txf_wr),
  .txf_full      (txf_full),
  .txf_data      (txf_data),
  .rxf_rd        (rxf_rd),
  .rxf_empty     (rxf_empty),
  .rx_byte_valid (rx_byte_valid),
  .busy          (busy),
  .done          (done),
  .len_err       (len_err),
  .no_tx_q       (no_tx_q),
  .no_rx_q       (no_rx_q)
);

// File: tb/test_spi_word_pack.sv
`timescale 1ns/1ps
module test_spi_word_pack;
  localparam int LEN_W  = 12;
  localparam int WORD_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [5:0]        cfg_bits = '0;
  logic [LEN_W-1:0]  cfg_len = '0;
  logic              cfg_no_tx = 1'b0;
  logic              cfg_no_rx = 1'b0;
  logic              tx_byte_valid = 1'b0;
  logic [7:0]        tx_byte = '0;
  logic              tx_byte_ready;
  logic              txf_full = 1'b0;
  logic              txf_wr;
  logic [WORD_W-1:0] txf_data;
  logic              rxf_empty = 1'b1;
  logic [WORD_W-1:0] rxf_data = '0;
  logic              rxf_rd;
  logic              rx_byte_valid;
  logic [7:0]        rx_byte;
  logic [LEN_W-1:0]  word_cnt;
  logic              busy;
  logic              done;
  logic              len_err;

  spi_word_pack #(.LEN_W(LEN_W), .WORD_W(WORD_W)) i_spi_word_pack (
    .clk, .rst, .start, .cfg_bits, .cfg_len, .cfg_no_tx, .cfg_no_rx,
    .tx_byte_valid, .tx_byte, .tx_byte_ready, .txf_full, .txf_wr, .txf_data,
    .rxf_empty, .rxf_data, .rxf_rd, .rx_byte_valid, .rx_byte,
    .word_cnt, .busy, .done, .len_err
  );

  always #2 clk = ~clk;

  int nchk = 0;
  int nerr = 0;

  logic [7:0]  txsrc [0:31];
  logic [31:0] rxw   [0:15];
  logic [31:0] txcap [0:15];
  logic [7:0]  rxcap [0:31];
  int tx_n, rx_n, tx_p, rx_p, ntx, nrx, viol;
  logic full_mode, empty_mode, saw_ready, done_seen;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setup(input int ntxb, input int nrxw);
    tx_n = ntxb; rx_n = nrxw; tx_p = 0; rx_p = 0;
    full_mode = 1'b0; empty_mode = 1'b0;
  endtask

  task automatic do_start(input logic [5:0] b, input int len, input logic ntx_m, input logic nrx_m);
    @(negedge clk);
    cfg_bits = b; cfg_len = LEN_W'(len); cfg_no_tx = ntx_m; cfg_no_rx = nrx_m;
    tx_byte_valid = 1'b0; rxf_empty = 1'b1; txf_full = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_xfer(input int max_cyc);
    int post;
    logic prev_full, acc_tx, rd;
    ntx = 0; nrx = 0; viol = 0; saw_ready = 1'b0; done_seen = 1'b0;
    post = 0; prev_full = 1'b0;
    for (int cyc = 0; cyc < max_cyc; cyc++) begin
      if (cyc != 0) @(negedge clk);
      txf_full      = full_mode && (cyc % 3 != 2);
      rxf_empty     = (rx_p >= rx_n) || (empty_mode && (cyc % 2 == 0));
      rxf_data      = (rx_p < rx_n) ? rxw[rx_p] : 32'h0;
      tx_byte_valid = tx_p < tx_n;
      tx_byte       = (tx_p < tx_n) ? txsrc[tx_p] : 8'h00;
      #1;
      if (txf_wr) begin
        if (prev_full) viol++;
        if (ntx < 16) txcap[ntx] = txf_data;
        ntx++;
      end
      if (rx_byte_valid) begin
        if (nrx < 32) rxcap[nrx] = rx_byte;
        nrx++;
      end
      if (tx_byte_ready) saw_ready = 1'b1;
      acc_tx = tx_byte_valid && tx_byte_ready;
      rd     = rxf_rd;
      if (rd && rxf_empty) viol++;
      if (done) done_seen = 1'b1;
      @(posedge clk);
      if (acc_tx) tx_p++;
      if (rd) rx_p++;
      prev_full = txf_full;
      if (done_seen) begin
        post++;
        if (post > 30) break;
      end
    end
    @(negedge clk);
    tx_byte_valid = 1'b0; rxf_empty = 1'b1; txf_full = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R12 busy", 32'(busy), 0);
    chk("R12 done", 32'(done), 0);
    chk("R12 len_err", 32'(len_err), 0);
    chk("R12 txf_wr", 32'(txf_wr), 0);
    chk("R12 rx_byte_valid", 32'(rx_byte_valid), 0);
    chk("R12 word_cnt", 32'(word_cnt), 0);
  endtask

  task automatic t_byte8;
    for (int i = 0; i < 4; i++) txsrc[i] = 8'(8'h11 * (i + 1));
    for (int i = 0; i < 4; i++) rxw[i] = 32'hA1 + 32'(i);
    setup(4, 4);
    do_start(6'd8, 4, 1'b0, 1'b0);
    run_xfer(200);
    chk("R2 word_cnt 8-bit", 32'(word_cnt), 4);
    chk("R10 done", 32'(done_seen), 1);
    chk("R10 busy low", 32'(busy), 0);
    chk("R3 word count 8-bit", 32'(ntx), 4);
    for (int i = 0; i < 4; i++) chk("R3 8-bit lane", txcap[i], {8'(8'h11 * (i + 1)), 24'h0});
    chk("R4 byte count 8-bit", 32'(nrx), 4);
    for (int i = 0; i < 4; i++) chk("R4 8-bit byte", 32'(rxcap[i]), 32'hA1 + 32'(i));
  endtask

  task automatic t_half16;
    for (int i = 0; i < 6; i++) txsrc[i] = 8'(i + 1);
    rxw[0] = 32'hDEAD1234; rxw[1] = 32'hBEEF5678; rxw[2] = 32'hFFFF9ABC;
    setup(6, 3);
    do_start(6'd16, 6, 1'b0, 1'b0);
    run_xfer(200);
    chk("R1 R2 word_cnt 16-bit", 32'(word_cnt), 3);
    chk("R3 16-bit w0", txcap[0], 32'h01020000);
    chk("R3 16-bit w1", txcap[1], 32'h03040000);
    chk("R3 16-bit w2", txcap[2], 32'h05060000);
    chk("R4 16-bit count", 32'(nrx), 6);
    chk("R4 16-bit b0", 32'(rxcap[0]), 32'h12);
    chk("R4 16-bit b1", 32'(rxcap[1]), 32'h34);
    chk("R4 16-bit b5", 32'(rxcap[5]), 32'hBC);
  endtask

  task automatic t_full32_stall;
    for (int i = 0; i < 8; i++) txsrc[i] = 8'hA0 + 8'(i);
    rxw[0] = 32'h12345678; rxw[1] = 32'h9ABCDEF0;
    setup(8, 2);
    full_mode = 1'b1; empty_mode = 1'b1;
    do_start(6'd32, 8, 1'b0, 1'b0);
    run_xfer(400);
    chk("R7 R8 flow violations", 32'(viol), 0);
    chk("R7 words after stall", 32'(ntx), 2);
    chk("R3 R7 32-bit w0", txcap[0], 32'hA0A1A2A3);
    chk("R3 R7 32-bit w1", txcap[1], 32'hA4A5A6A7);
    chk("R8 bytes after gaps", 32'(nrx), 8);
    chk("R4 R8 32-bit b0", 32'(rxcap[0]), 32'h12);
    chk("R4 R8 32-bit b3", 32'(rxcap[3]), 32'h78);
    chk("R4 R8 32-bit b4", 32'(rxcap[4]), 32'h9A);
    chk("R4 R8 32-bit b7", 32'(rxcap[7]), 32'hF0);
  endtask

  task automatic t_sizes;
    int bl [6];
    int ex [6];
    bl = '{1, 8, 9, 16, 17, 32};
    ex = '{8, 8, 4, 4, 2, 2};
    for (int i = 0; i < 16; i++) rxw[i] = 32'(i);
    for (int k = 0; k < 6; k++) begin
      setup(0, 16);
      do_start(6'(bl[k]), 8, 1'b1, 1'b1);
      run_xfer(200);
      chk($sformatf("R1 R2 word_cnt bits=%0d", bl[k]), 32'(word_cnt), 32'(ex[k]));
      chk($sformatf("R1 R9 reads bits=%0d", bl[k]), 32'(rx_p), 32'(ex[k]));
    end
  endtask

  task automatic t_no_tx;
    for (int i = 0; i < 4; i++) txsrc[i] = 8'hFF;
    rxw[0] = 32'h1111; rxw[1] = 32'h2222;
    setup(4, 2);
    do_start(6'd16, 4, 1'b1, 1'b0);
    run_xfer(200);
    chk("R5 dummy words", 32'(ntx), 2);
    chk("R5 dummy w0 zero", txcap[0], 0);
    chk("R5 dummy w1 zero", txcap[1], 0);
    chk("R5 ready never", 32'(saw_ready), 0);
    chk("R5 bytes untaken", 32'(tx_p), 0);
  endtask

  task automatic t_no_rx;
    for (int i = 0; i < 8; i++) txsrc[i] = 8'(i);
    rxw[0] = 32'hCAFEF00D; rxw[1] = 32'h01020304; rxw[2] = 32'h55555555;
    setup(8, 3);
    do_start(6'd32, 8, 1'b0, 1'b1);
    run_xfer(200);
    chk("R6 pops", 32'(rx_p), 2);
    chk("R6 no bytes out", 32'(nrx), 0);
    chk("R6 done", 32'(done_seen), 1);
  endtask

  task automatic t_len_stop;
    for (int i = 0; i < 6; i++) txsrc[i] = 8'h30 + 8'(i);
    for (int i = 0; i < 5; i++) rxw[i] = 32'h40 + 32'(i);
    setup(6, 5);
    do_start(6'd8, 3, 1'b0, 1'b0);
    run_xfer(200);
    chk("R9 tx bytes taken", 32'(tx_p), 3);
    chk("R9 tx words", 32'(ntx), 3);
    chk("R9 rx pops", 32'(rx_p), 3);
    chk("R9 rx bytes", 32'(nrx), 3);
    chk("R9 last tx word", txcap[2], 32'h32000000);
  endtask

  task automatic t_len_err;
    for (int i = 0; i < 6; i++) txsrc[i] = 8'h77;
    rxw[0] = 32'h1; rxw[1] = 32'h2;
    setup(6, 2);
    do_start(6'd32, 6, 1'b0, 1'b0);
    chk("R11 len_err", 32'(len_err), 1);
    chk("R11 busy low", 32'(busy), 0);
    chk("R11 R2 word_cnt", 32'(word_cnt), 0);
    run_xfer(20);
    chk("R11 no bytes taken", 32'(tx_p), 0);
    chk("R11 no writes", 32'(ntx), 0);
    chk("R11 no pops", 32'(rx_p), 0);
    chk("R11 not done", 32'(done_seen), 0);
  endtask

  initial begin
    #(4.0 * 100000);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_byte8();
    t_half16();
    t_full32_stall();
    t_sizes();
    t_no_tx();
    t_no_rx();
    t_len_stop();
    t_len_err();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule